// File: doc/BRIEF.md
# SD Card Command Path Controller

This block is the command half of an SD/MMC host. A write to the command word starts a transfer, provided the enable bit is set and the block is idle. The block shifts a 48-bit command frame out on the command line, one bit per clock, and ends it with a CRC7. Depending on the response-type field it then either finishes at once or waits for the card to answer with a 48-bit or a 136-bit response. It checks the response CRC where the type asks for it and stores the payload in four response words. It raises exactly one outcome event per command: sent, response received, CRC failure or timeout.

After a short response the block also looks at data line 0. If the card holds that line low, a busy status is shown. The busy phase ends with a busy-end event when the card releases the line. It ends with a data-timeout event instead if the data timer, latched at the start of the command, expires first. Clock division, the data path and DMA lie outside this block. Here the card clock is the block clock.

Top module: `sdc_cmd_path`

## Requirements
- R1: A write with command-word bit 12 set, made while idle, starts a command. Bits 5:0 of the word give the index and bits 9:8 the response type. The start clears every event flag, and from the next cycle on the block is active and drives the start bit.
- R2: The command line carries 48 bits, one per cycle, starting the cycle after the write, with output enable high throughout. The bits are 0, 1, the index MSB first, the argument MSB first, a CRC7 and a final 1.
- R3: The CRC7 uses the polynomial x^7+x^3+1 with a zero seed. It covers the first 40 frame bits and is sent MSB first.
- R4: Response type 00 raises the sent event in the cycle after the end bit and returns the block to idle.
- R5: For types 01, 10 and 11, a start bit (0) must arrive within the 64 cycles that follow the cycle after the end bit. If none arrives, the timeout event rises at the end of that window and the block goes idle.
- R6: A short response is 48 bits, and its CRC covers its first 40 bits. Type 01 raises the CRC-fail event on a mismatch and the response event otherwise. Type 10 raises the response event whatever the CRC.
- R7: A type 11 response is 136 bits: 0, 0, six check bits, 120 payload bits, a CRC7 over those 120 bits, and a 1. A good CRC raises the response event, and a bad one raises CRC-fail.
- R8: A short response writes its 32 bits after the index field into word 1 and leaves words 2 to 4 unchanged. A long response writes the 128 bits after the check field into words 1 to 4, with word 1 holding the first 32.
- R9: After a short response, data line 0 is sampled in the cycle after the response end bit. If it is low, busy_d0 rises; the first later cycle that samples it high raises the busy-end event and clears busy.
- R10: The busy phase samples D0 once per cycle, counting samples from 0. If D0 is still low at sample number N, where N is the data timer, the data-timeout event rises instead, busy clears and no busy-end follows.
- R11: A command-word write with bit 12 clear disables an active command at once. Output enable falls, and no further event is raised for that command.
- R12: After reset the block is idle, output enable is low, all events and busy are low and the response words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the card clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command-word write strobe |
| cmd_word | input | 16 | Command word: index, response type, enable |
| cmd_arg | input | 32 | Command argument, taken at the start |
| dtimer | input | 32 | Busy data timer, taken at the start |
| cmd_in | input | 1 | Command line from the card |
| d0_in | input | 1 | Data line 0 from the card |
| cmd_out | output | 1 | Command line to the card |
| cmd_oe | output | 1 | Command line output enable |
| resp1 | output | 32 | Response word 1 |
| resp2 | output | 32 | Response word 2 |
| resp3 | output | 32 | Response word 3 |
| resp4 | output | 32 | Response word 4 |
| cmd_active | output | 1 | Command state machine busy |
| evt_sent | output | 1 | Command sent (no response) |
| evt_rend | output | 1 | Response received |
| evt_crcfail | output | 1 | Response CRC mismatch |
| evt_ctimeout | output | 1 | No response in time |
| busy_d0 | output | 1 | Card holds D0 low after response |
| evt_busyend | output | 1 | D0 released |
| evt_dtimeout | output | 1 | Data timer expired during busy |

## Verification
The frame encoder is swept over all 64 indices with arguments that change per index. This catches index and argument bit ordering errors and CRC errors, which a single command would hide. Each response type gets a good response and a corrupted-CRC response. Together these separate the CRC-checked types from the unchecked one, and the short storage from the long storage. The response window and the data timer are both hit one cycle inside and one cycle past their limits, which tells an off-by-one apart from correct timing. A disable is issued both mid-frame and while waiting for a response.

// File: rtl/sdc_pkg.sv
// Package: shared encodings and the serial CRC7 step for the command path.
// Assumes one CRC bit per call, MSB-first data order.
package sdc_pkg;

    // Command-word field positions (software decodes these)
    localparam int CW_IDX_LSB = 0;
    localparam int CW_RT_LSB  = 8;
    localparam int CW_EN_BIT  = 12;

    // Response-type encodings
    localparam logic [1:0] RT_NONE    = 2'b00;
    localparam logic [1:0] RT_SHORT   = 2'b01;
    localparam logic [1:0] RT_NOCRC   = 2'b10;
    localparam logic [1:0] RT_LONG    = 2'b11;

    localparam int CRC_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_RECV,
        ST_BUSY
    } cp_state_t;

    // One step of CRC7 (x^7 + x^3 + 1) for one incoming bit
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[6] ^ b;
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

endpackage

// File: rtl/sdc_cmd_tx.sv
// Module: command frame serializer.
// Loads a header (start, direction, index, argument), shifts it out MSB
// first while building CRC7, then sends the CRC and an end bit.
// Assumes one bit per clock; 'kill' aborts and releases the line.
module sdc_cmd_tx
    import sdc_pkg::*;
#(
    parameter int HDR_W = 40,
    parameter int FRM_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kill,
    input  logic             load,
    input  logic [HDR_W-1:0] frame,
    output logic             bit_out,
    output logic             oe,
    output logic             done
);
    localparam int CW = $clog2(FRM_W);
    localparam logic [CW-1:0] HDR_END = CW'(HDR_W);
    localparam logic [CW-1:0] CRC_END = CW'(HDR_W + CRC_W);
    localparam logic [CW-1:0] LAST    = CW'(FRM_W - 1);

    logic [HDR_W-1:0] sreg;
    logic [CRC_W-1:0] crc;
    logic [CW-1:0]    cnt;
    logic             run;

    // Shift the header, accumulate then shift out the CRC, count bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
            crc  <= '0;
            cnt  <= '0;
            run  <= 1'b0;
        end else if (kill) begin
            run <= 1'b0;
        end else if (load) begin
            sreg <= frame;
            crc  <= '0;
            cnt  <= '0;
            run  <= 1'b1;
        end else if (run) begin
            cnt <= cnt + 1'b1;
            if (cnt < HDR_END) begin
                crc  <= crc7_step(crc, sreg[HDR_W-1]);
                sreg <= {sreg[HDR_W-2:0], 1'b0};
            end else begin
                crc <= {crc[CRC_W-2:0], 1'b0};
            end
            if (cnt == LAST) run <= 1'b0;
        end
    end

    // Select the bit on the line for the current position
    always_comb begin
        if (!run)                bit_out = 1'b1;
        else if (cnt < HDR_END)  bit_out = sreg[HDR_W-1];
        else if (cnt < CRC_END)  bit_out = crc[CRC_W-1];
        else                     bit_out = 1'b1;
    end

    assign oe   = run;
    assign done = run && (cnt == LAST);

endmodule

// File: rtl/sdc_resp_rx.sv
// Module: response deserializer.
// While armed, hunts for a start bit; then collects a short or long frame,
// runs CRC7 over the covered bits plus the received CRC (zero remainder =
// good) and keeps the last SAVE_W bits. 'done' pulses one cycle after the
// end bit is sampled, with crc_ok and save valid from then on.
module sdc_resp_rx
    import sdc_pkg::*;
#(
    parameter int SHORT_LEN = 48,
    parameter int LONG_LEN  = 136,
    parameter int HEAD_W    = 8,
    parameter int SAVE_W    = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kill,
    input  logic              arm,
    input  logic              long_mode,
    input  logic              bit_in,
    output logic              started,
    output logic              done,
    output logic              crc_ok,
    output logic [SAVE_W-1:0] save
);
    localparam int CW = $clog2(LONG_LEN + 1);
    localparam logic [CW-1:0] S_LAST  = CW'(SHORT_LEN - 1);
    localparam logic [CW-1:0] L_LAST  = CW'(LONG_LEN - 1);
    localparam logic [CW-1:0] S_FEED  = CW'(SHORT_LEN - 2);
    localparam logic [CW-1:0] L_FEED  = CW'(LONG_LEN - 2);
    localparam logic [CW-1:0] L_FIRST = CW'(HEAD_W);

    logic [CW-1:0]    cnt;
    logic [CRC_W-1:0] crc;
    logic             rcv;
    logic             feed;
    logic [CW-1:0]    last;

    assign started = arm && !rcv && !bit_in;
    assign last    = long_mode ? L_LAST : S_LAST;
    assign feed    = long_mode ? (cnt >= L_FIRST && cnt <= L_FEED) : (cnt <= S_FEED);

    // Capture bits, update CRC over the covered span, flag completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            crc    <= '0;
            rcv    <= 1'b0;
            done   <= 1'b0;
            crc_ok <= 1'b0;
            save   <= '0;
        end else if (kill) begin
            rcv  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (started) begin
                rcv  <= 1'b1;
                cnt  <= CW'(1);
                crc  <= '0;
                save <= {save[SAVE_W-2:0], 1'b0};
            end else if (rcv) begin
                save <= {save[SAVE_W-2:0], bit_in};
                cnt  <= cnt + 1'b1;
                if (feed) crc <= crc7_step(crc, bit_in);
                if (cnt == last) begin
                    rcv    <= 1'b0;
                    done   <= 1'b1;
                    crc_ok <= (crc == '0);
                end
            end
        end
    end

endmodule

// File: rtl/sdc_cmd_path.sv
// Module: command path state machine (top).
// Starts a command on a command-word write with the enable bit, serializes
// it, waits for the selected response kind, checks CRC, stores response
// words, raises one outcome event, and tracks D0 busy after short responses.
// Assumes cmd_in/d0_in are already synchronous to clk (card clock = clk).
module sdc_cmd_path
    import sdc_pkg::*;
#(
    parameter int IDX_W    = 6,
    parameter int ARG_W    = 32,
    parameter int CMDW_W   = 16,
    parameter int DT_W     = 32,
    parameter int RESP_TMO = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CMDW_W-1:0] cmd_word,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic [DT_W-1:0]   dtimer,
    input  logic              cmd_in,
    input  logic              d0_in,
    output logic              cmd_out,
    output logic              cmd_oe,
    output logic [ARG_W-1:0]  resp1,
    output logic [ARG_W-1:0]  resp2,
    output logic [ARG_W-1:0]  resp3,
    output logic [ARG_W-1:0]  resp4,
    output logic              cmd_active,
    output logic              evt_sent,
    output logic              evt_rend,
    output logic              evt_crcfail,
    output logic              evt_ctimeout,
    output logic              busy_d0,
    output logic              evt_busyend,
    output logic              evt_dtimeout
);
    localparam int NWORDS    = 4;
    localparam int HEAD_W    = 2 + IDX_W;
    localparam int HDR_W     = HEAD_W + ARG_W;
    localparam int SHORT_LEN = HDR_W + CRC_W + 1;
    localparam int SAVE_W    = NWORDS * ARG_W;
    localparam int LONG_LEN  = HEAD_W + SAVE_W;
    localparam int TMO_W     = $clog2(RESP_TMO);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(RESP_TMO - 1);

    cp_state_t         state;
    logic [1:0]        rtype;
    logic [DT_W-1:0]   dt_lim;
    logic [DT_W-1:0]   dt_cnt;
    logic [TMO_W-1:0]  tmo_cnt;
    logic [ARG_W-1:0]  resp_q [NWORDS];

    logic start, stop, is_long, crc_checked;
    logic tx_done, rx_started, rx_done, rx_crc_ok;
    logic [SAVE_W-1:0] rx_save;
    logic [HDR_W-1:0]  hdr;

    assign start       = cmd_wr && cmd_word[CW_EN_BIT] && (state == ST_IDLE);
    assign stop        = cmd_wr && !cmd_word[CW_EN_BIT] && (state != ST_IDLE);
    assign is_long     = (rtype == RT_LONG);
    assign crc_checked = (rtype == RT_SHORT) || (rtype == RT_LONG);
    assign hdr         = {1'b0, 1'b1, cmd_word[CW_IDX_LSB +: IDX_W], cmd_arg};

    sdc_cmd_tx #(
        .HDR_W (HDR_W),
        .FRM_W (SHORT_LEN)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .kill    (stop),
        .load    (start),
        .frame   (hdr),
        .bit_out (cmd_out),
        .oe      (cmd_oe),
        .done    (tx_done)
    );

    sdc_resp_rx #(
        .SHORT_LEN (SHORT_LEN),
        .LONG_LEN  (LONG_LEN),
        .HEAD_W    (HEAD_W),
        .SAVE_W    (SAVE_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .kill      (stop),
        .arm       (state == ST_WAIT),
        .long_mode (is_long),
        .bit_in    (cmd_in),
        .started   (rx_started),
        .done      (rx_done),
        .crc_ok    (rx_crc_ok),
        .save      (rx_save)
    );

    // Sequence the command, response wait, response check and busy phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            rtype        <= RT_NONE;
            dt_lim       <= '0;
            dt_cnt       <= '0;
            tmo_cnt      <= '0;
            evt_sent     <= 1'b0;
            evt_rend     <= 1'b0;
            evt_crcfail  <= 1'b0;
            evt_ctimeout <= 1'b0;
            busy_d0      <= 1'b0;
            evt_busyend  <= 1'b0;
            evt_dtimeout <= 1'b0;
        end else if (stop) begin
            state   <= ST_IDLE;
            busy_d0 <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state        <= ST_SEND;
                    rtype        <= cmd_word[CW_RT_LSB +: 2];
                    dt_lim       <= dtimer;
                    evt_sent     <= 1'b0;
                    evt_rend     <= 1'b0;
                    evt_crcfail  <= 1'b0;
                    evt_ctimeout <= 1'b0;
                    evt_busyend  <= 1'b0;
                    evt_dtimeout <= 1'b0;
                end
                ST_SEND: if (tx_done) begin
                    tmo_cnt <= '0;
                    if (rtype == RT_NONE) begin
                        evt_sent <= 1'b1;
                        state    <= ST_IDLE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (rx_started) begin
                        state <= ST_RECV;
                    end else if (tmo_cnt == TMO_LAST) begin
                        evt_ctimeout <= 1'b1;
                        state        <= ST_IDLE;
                    end else begin
                        tmo_cnt <= tmo_cnt + 1'b1;
                    end
                end
                ST_RECV: if (rx_done) begin
                    if (crc_checked && !rx_crc_ok) begin
                        evt_crcfail <= 1'b1;
                        state       <= ST_IDLE;
                    end else begin
                        evt_rend <= 1'b1;
                        if (!is_long && !d0_in) begin
                            busy_d0 <= 1'b1;
                            dt_cnt  <= '0;
                            state   <= ST_BUSY;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_BUSY: begin
                    if (d0_in) begin
                        evt_busyend <= 1'b1;
                        busy_d0     <= 1'b0;
                        state       <= ST_IDLE;
                    end else if (dt_cnt == dt_lim) begin
                        evt_dtimeout <= 1'b1;
                        busy_d0      <= 1'b0;
                        state        <= ST_IDLE;
                    end else begin
                        dt_cnt <= dt_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Response word storage: all words for long, word 1 only for short
    for (genvar g = 0; g < NWORDS; g++) begin : g_resp
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                resp_q[g] <= '0;
            end else if (!stop && state == ST_RECV && rx_done) begin
                if (is_long)
                    resp_q[g] <= rx_save[SAVE_W-1-g*ARG_W -: ARG_W];
                else if (g == 0)
                    resp_q[g] <= rx_save[SHORT_LEN-1-HEAD_W -: ARG_W];
            end
        end
    end

    assign resp1      = resp_q[0];
    assign resp2      = resp_q[1];
    assign resp3      = resp_q[2];
    assign resp4      = resp_q[3];
    assign cmd_active = (state != ST_IDLE);

endmodule

// File: rtl/sdc_cmd_path_chk.sv
// Module: property checker for the command path, bound to the top.
// Assumes it sees only top-level ports.
module sdc_cmd_path_chk #(
    parameter int CMDW_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic [CMDW_W-1:0] cmd_word,
    input logic              cmd_out,
    input logic              cmd_oe,
    input logic              cmd_active,
    input logic              evt_sent,
    input logic              evt_rend,
    input logic              evt_crcfail,
    input logic              evt_ctimeout,
    input logic              busy_d0,
    input logic              evt_busyend,
    input logic              evt_dtimeout
);
    // R2
    oe_needs_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> cmd_active);

    // R1
    start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_word[12] && !cmd_active) |=>
        (cmd_active && cmd_oe && !cmd_out && !evt_sent && !evt_rend &&
         !evt_crcfail && !evt_ctimeout && !evt_busyend && !evt_dtimeout));

    // R6
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_sent, evt_rend, evt_crcfail, evt_ctimeout}));

    // R9
    busy_after_rend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_d0 |-> evt_rend);

    // R10
    busy_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_busyend && evt_dtimeout));

    // R11
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cmd_word[12]) |=> (!cmd_active && !cmd_oe && !busy_d0));

endmodule

bind sdc_cmd_path sdc_cmd_path_chk #(.CMDW_W(CMDW_W)) u_chk (.*);

// File: tb/sdc_cmd_path_tb.sv
`timescale 1ns/1ps
module sdc_cmd_path_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_wr = 1'b0;
    logic [15:0]  cmd_word = '0;
    logic [31:0]  cmd_arg = '0;
    logic [31:0]  dtimer = '0;
    logic         cmd_in = 1'b1;
    logic         d0_in = 1'b1;
    logic         cmd_out, cmd_oe, cmd_active;
    logic [31:0]  resp1, resp2, resp3, resp4;
    logic         evt_sent, evt_rend, evt_crcfail, evt_ctimeout;
    logic         busy_d0, evt_busyend, evt_dtimeout;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    sdc_cmd_path u_dut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // CRC7, x^7+x^3+1, over n bits of v starting at bit hi downwards
    function automatic logic [6:0] crc_of(input logic [135:0] v, input int hi, input int n);
        logic [6:0] c = '0;
        for (int i = 0; i < n; i++) begin
            logic fb = c[6] ^ v[hi - i];
            c = {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
        end
        return c;
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [39:0] h = {2'b01, idx, arg};
        return {h, crc_of({96'b0, h}, 39, 40), 1'b1};
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] st, input bit good);
        logic [39:0] h = {2'b00, idx, st};
        logic [6:0]  c = crc_of({96'b0, h}, 39, 40) ^ (good ? 7'h00 : 7'h01);
        return {88'b0, h, c, 1'b1};
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] pl, input bit good);
        logic [6:0] c = crc_of({16'b0, pl}, 119, 120) ^ (good ? 7'h00 : 7'h40);
        return {2'b00, 6'b111111, pl, c, 1'b1};
    endfunction

    // Write the command word; capture ncap line bits (one per cycle)
    task automatic issue(input logic [5:0] idx, input logic [1:0] rt, input logic [31:0] arg,
                         input logic [31:0] dt, input int ncap,
                         output logic [47:0] got, output bit oe_all);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = {3'b0, 1'b1, 2'b0, rt, 2'b0, idx};
        cmd_arg = arg; dtimer = dt;
        @(posedge clk);
        @(negedge clk);
        cmd_wr = 1'b0;
        got = '0; oe_all = 1'b1;
        for (int k = 0; k < ncap; k++) begin
            if (k > 0) @(negedge clk);
            got = {got[46:0], cmd_out};
            if (!cmd_oe) oe_all = 1'b0;
        end
    endtask

    // From the cycle after the end bit: start bit sampled at WAIT edge k
    task automatic drive_resp(input logic [135:0] fr, input int len, input int k, input logic d0v);
        d0_in = d0v;
        repeat (k + 1) @(negedge clk);
        for (int p = 0; p < len; p++) begin
            if (p > 0) @(negedge clk);
            cmd_in = fr[len - 1 - p];
        end
        @(negedge clk);
        cmd_in = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_word(input logic [15:0] w);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [47:0]  got;
        bit           oe_all;
        logic [135:0] fr;
        logic [119:0] pl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        chk(!cmd_active && !cmd_oe && cmd_out, "R12 idle", {cmd_active, cmd_oe, cmd_out}, 3'b001);
        chk({evt_sent, evt_rend, evt_crcfail, evt_ctimeout, busy_d0, evt_busyend, evt_dtimeout} == 0,
            "R12 events", {evt_sent, evt_rend, evt_crcfail, evt_ctimeout, busy_d0, evt_busyend, evt_dtimeout}, 0);
        chk({resp1, resp2, resp3, resp4} == 0, "R12 resp", {resp1, resp2, resp3, resp4}, 0);

        // R2 R3 R4: sweep all indices with no-response commands
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a = 32'h9E3779B9 * (i + 1) ^ {26'b0, i[5:0]};
            issue(i[5:0], 2'b00, a, 0, 48, got, oe_all);
            chk(got == exp_frame(i[5:0], a) && oe_all, "R2 R3 frame", got, exp_frame(i[5:0], a));
            @(negedge clk);
            chk(evt_sent && !cmd_active && !cmd_oe, "R4 sent", {evt_sent, cmd_active, cmd_oe}, 3'b100);
        end
        // CMD0 argument 0 known CRC 0x4A
        issue(6'd0, 2'b00, 32'h0, 0, 48, got, oe_all);
        chk(got[7:1] == 7'h4A, "R3 known crc", got[7:1], 7'h4A);
        @(negedge clk);

        // R7 R8: long response with good CRC
        pl = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'h5A5A5A};
        fr = mk_long(pl, 1'b1);
        issue(6'd2, 2'b11, 32'h0, 0, 48, got, oe_all);
        drive_resp(fr, 136, 3, 1'b1);
        chk(evt_rend && !evt_crcfail && !cmd_active, "R7 long good", {evt_rend, evt_crcfail, cmd_active}, 3'b100);
        chk({resp1, resp2, resp3, resp4} == fr[127:0], "R8 long words", {resp1, resp2, resp3, resp4}, fr[127:0]);

        // R8 R6: short response, type 01, good CRC; words 2..4 kept
        issue(6'd13, 2'b01, 32'h00000AAA, 0, 48, got, oe_all);
        drive_resp(mk_short(6'd13, 32'hCAFEF00D, 1'b1), 48, 0, 1'b1);
        chk(evt_rend && !evt_crcfail && !cmd_active, "R6 short good", {evt_rend, evt_crcfail, cmd_active}, 3'b100);
        chk(resp1 == 32'hCAFEF00D, "R8 short word1", resp1, 32'hCAFEF00D);
        chk({resp2, resp3, resp4} == fr[95:0], "R8 words kept", {resp2, resp3, resp4}, fr[95:0]);

        // R6: type 01 bad CRC -> CRC fail
        issue(6'd17, 2'b01, 32'h1, 0, 48, got, oe_all);
        drive_resp(mk_short(6'd17, 32'h12345678, 1'b0), 48, 5, 1'b1);
        chk(evt_crcfail && !evt_rend, "R6 short crcfail", {evt_crcfail, evt_rend}, 2'b10);

        // R6: type 10 bad CRC -> still received
        issue(6'd41, 2'b10, 32'h2, 0, 48, got, oe_all);
        drive_resp(mk_short(6'd63, 32'h00FF00FF, 1'b0), 48, 1, 1'b1);
        chk(evt_rend && !evt_crcfail, "R6 nocrc accepted", {evt_rend, evt_crcfail}, 2'b10);
        chk(resp1 == 32'h00FF00FF, "R8 nocrc word1", resp1, 32'h00FF00FF);

        // R7: long bad CRC
        issue(6'd9, 2'b11, 32'h3, 0, 48, got, oe_all);
        drive_resp(mk_long(~pl, 1'b0), 136, 0, 1'b1);
        chk(evt_crcfail && !evt_rend, "R7 long crcfail", {evt_crcfail, evt_rend}, 2'b10);

        // R5: start bit at the last accepted window cycle
        issue(6'd55, 2'b01, 32'h4, 0, 48, got, oe_all);
        drive_resp(mk_short(6'd55, 32'hA5A5A5A5, 1'b1), 48, 63, 1'b1);
        chk(evt_rend && !evt_ctimeout, "R5 late accept", {evt_rend, evt_ctimeout}, 2'b10);

        // R5: no response -> timeout exactly at window end
        issue(6'd8, 2'b01, 32'h5, 0, 48, got, oe_all);
        repeat (64) @(negedge clk);
        chk(!evt_ctimeout && cmd_active, "R5 not yet", {evt_ctimeout, cmd_active}, 2'b01);
        @(negedge clk);
        chk(evt_ctimeout && !cmd_active, "R5 timeout", {evt_ctimeout, cmd_active}, 2'b10);

        // R1: new start clears previous event
        issue(6'd1, 2'b00, 32'h6, 0, 1, got, oe_all);
        chk(!evt_ctimeout && cmd_active && got[0] == 1'b0, "R1 start clears", {evt_ctimeout, cmd_active, got[0]}, 3'b010);
        repeat (48) @(negedge clk);

        // R9: busy released at sample N -> busy end
        issue(6'd7, 2'b01, 32'h7, 10, 48, got, oe_all);
        drive_resp(mk_short(6'd7, 32'h900, 1'b1), 48, 0, 1'b0);
        chk(busy_d0 && evt_rend && cmd_active, "R9 busy set", {busy_d0, evt_rend, cmd_active}, 3'b111);
        repeat (10) @(negedge clk);
        d0_in = 1'b1;
        @(negedge clk);
        chk(evt_busyend && !evt_dtimeout && !busy_d0 && !cmd_active, "R9 busy end",
            {evt_busyend, evt_dtimeout, busy_d0, cmd_active}, 4'b1000);

        // R10: still low at sample N -> data timeout
        issue(6'd7, 2'b01, 32'h8, 10, 48, got, oe_all);
        drive_resp(mk_short(6'd7, 32'h900, 1'b1), 48, 0, 1'b0);
        repeat (10) @(negedge clk);
        chk(busy_d0 && !evt_dtimeout, "R10 before limit", {busy_d0, evt_dtimeout}, 2'b10);
        @(negedge clk);
        chk(evt_dtimeout && !busy_d0 && !cmd_active, "R10 dtimeout", {evt_dtimeout, busy_d0, cmd_active}, 3'b100);
        d0_in = 1'b1;
        @(negedge clk);
        chk(!evt_busyend, "R10 no busy end", evt_busyend, 1'b0);

        // R9: D0 high after response -> no busy
        issue(6'd7, 2'b10, 32'h9, 10, 48, got, oe_all);
        drive_resp(mk_short(6'd7, 32'h1, 1'b1), 48, 2, 1'b1);
        chk(!busy_d0 && !cmd_active, "R9 no busy", {busy_d0, cmd_active}, 2'b00);

        // R11: disable mid-frame
        issue(6'd20, 2'b01, 32'hFFFF0000, 0, 20, got, oe_all);
        write_word(16'h0000);
        chk(!cmd_active && !cmd_oe, "R11 stop mid frame", {cmd_active, cmd_oe}, 2'b00);
        repeat (100) @(negedge clk);
        chk(!evt_ctimeout && !evt_sent && !cmd_oe, "R11 no event", {evt_ctimeout, evt_sent, cmd_oe}, 3'b000);

        // R11: disable while waiting, then late response is ignored
        issue(6'd21, 2'b01, 32'h1234, 0, 48, got, oe_all);
        repeat (5) @(negedge clk);
        write_word(16'h0000);
        chk(!cmd_active, "R11 stop in wait", cmd_active, 1'b0);
        drive_resp(mk_short(6'd21, 32'h77777777, 1'b1), 48, 0, 1'b1);
        repeat (70) @(negedge clk);
        chk(!evt_rend && !evt_ctimeout && resp1 == 32'h1, "R11 response ignored",
            {evt_rend, evt_ctimeout, resp1}, {2'b00, 32'h1});

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule